// File: doc/BRIEF.md
# UART Modem Control and Status Registers

This block is the modem-handshake corner of a 16550-style serial port. It holds a small control register that drives four active-low handshake outputs: terminal ready, request to send, and two general-purpose outputs. It also offers a status register that reports the asserted level of four active-low handshake inputs: clear to send, data set ready, ring, and carrier detect. Each input passes through a synchroniser before it is used.

Alongside the levels, the status register keeps four sticky change flags. Clear to send, data set ready and carrier detect flag any transition. The ring flag is set only when the ring line stops being asserted. All four flags are cleared by a status read, and an interrupt request stays high while any of them is set. A loopback mode disconnects the external handshake pins. The control bits then feed the status levels inside the block, and the outputs are parked in their inactive state.

Top module: `modem_ctl_stat`

## Requirements
- R1: The control register sits at offset 4. Bits 4:0 are written by a write to that offset and read back there, bits 7:5 read as 0, and after reset the register reads 0.
- R2: With bit 4 of the control register clear, each output is the inverse of its control bit: dtr_n is bit 0, rts_n is bit 1, out1_n is bit 2 and out2_n is bit 3.
- R3: With bit 4 of the control register set (loopback), dtr_n, rts_n, out1_n and out2_n all stay at 1.
- R4: The status register sits at offset 6. Bits 7:4 report the asserted (pin low) level of cts_n, dsr_n, ri_n and dcd_n at bits 4, 5, 6 and 7. A pin change appears there after the second rising clock edge that samples it.
- R5: In loopback, the status levels come from the control register: CTS takes bit 1, DSR takes bit 0, RI takes bit 2 and DCD takes bit 3. The external input pins have no effect.
- R6: Status bits 0, 1 and 3 are set one clock after the CTS, DSR or DCD level, respectively, changes in either direction.
- R7: Status bit 2 is set only when the RI level goes from asserted to deasserted. It is never set when RI becomes asserted.
- R8: The change bits stay set until a clock edge where rd_en is high with the address at offset 6. That edge clears them, except for a change detected at that same edge, which stays set.
- R9: irq is high exactly while any of status bits 3:0 is set.
- R10: Reads at any address other than 4 and 6 return 0. Writes to any other address leave the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; a status read clears the change bits |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| cts_n | input | 1 | Clear-to-send input, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready input, active low, asynchronous |
| ri_n | input | 1 | Ring input, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect input, active low, asynchronous |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| out1_n | output | 1 | General-purpose output 1, active low |
| out2_n | output | 1 | General-purpose output 2, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that wr_en, rd_en, addr and wdata are synchronous to clk and stable around each rising edge. Only the four handshake pins may be asynchronous. The bench drives every input on the falling edge, so each pin change is sampled cleanly by the synchroniser. It applies strobes and addresses for exactly the edge they are meant for, including a status read placed on the same edge as a freshly detected change. It holds reset long enough for the synchroniser to start from the idle level before the first comparison.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int LINE_N  = 4;
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;

    localparam int CTRL_W  = 5;
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_OUT1 = 2;
    localparam int CB_OUT2 = 3;
    localparam int CB_LOOP = 4;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [LINE_N-1:0] prev;
        logic [LINE_N-1:0] delta;
    } mdm_state_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], din[g]};
            end
            assign dout[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
(
    input  logic [LINE_N-1:0] prev,
    input  logic [LINE_N-1:0] cur,
    output logic [LINE_N-1:0] chg
);
    genvar g;
    generate
        for (g = 0; g < LINE_N; g++) begin : g_det
            if (g == IDX_RI) begin : g_trail
                // ring: only the end of an asserted period counts
                assign chg[g] = prev[g] & ~cur[g];
            end else begin : g_any
                assign chg[g] = prev[g] ^ cur[g];
            end
        end
    endgenerate
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
    import mdm_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int CTRL_OFS    = 4,
    parameter int STAT_OFS    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              out1_n,
    output logic              out2_n,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    mdm_state_t st_d, st_q;

    logic [LINE_N-1:0] pin_lvl, sync_lvl, loop_lvl, lvl, chg;
    logic [LINE_N-1:0] delta_q, prev_q;
    logic              loop_on, ctrl_wr, stat_rd;
    logic [2:0]        unused_wdata_hi;

    assign unused_wdata_hi = wdata[7:5];

    // asserted level of each pin, in status-bit order
    assign pin_lvl[IDX_CTS] = ~cts_n;
    assign pin_lvl[IDX_DSR] = ~dsr_n;
    assign pin_lvl[IDX_RI]  = ~ri_n;
    assign pin_lvl[IDX_DCD] = ~dcd_n;

    mdm_sync #(.WIDTH(LINE_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_lvl),
        .dout (sync_lvl)
    );

    assign delta_q = st_q.delta;
    assign prev_q  = st_q.prev;
    assign loop_on = st_q.ctrl[CB_LOOP];

    // internal wiring of control bits to status levels in loopback
    assign loop_lvl[IDX_CTS] = st_q.ctrl[CB_RTS];
    assign loop_lvl[IDX_DSR] = st_q.ctrl[CB_DTR];
    assign loop_lvl[IDX_RI]  = st_q.ctrl[CB_OUT1];
    assign loop_lvl[IDX_DCD] = st_q.ctrl[CB_OUT2];

    assign lvl = loop_on ? loop_lvl : sync_lvl;

    mdm_delta u_delta (
        .prev(prev_q),
        .cur (lvl),
        .chg (chg)
    );

    assign ctrl_wr = wr_en && (addr == CTRL_A);
    assign stat_rd = rd_en && (addr == STAT_A);

    always_comb begin
        st_d       = st_q;
        st_d.prev  = lvl;
        st_d.delta = (stat_rd ? '0 : st_q.delta) | chg;
        if (ctrl_wr) st_d.ctrl = wdata[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_A)      rdata[CTRL_W-1:0] = st_q.ctrl;
        else if (addr == STAT_A) rdata = {lvl, delta_q};
    end

    assign dtr_n  = loop_on | ~st_q.ctrl[CB_DTR];
    assign rts_n  = loop_on | ~st_q.ctrl[CB_RTS];
    assign out1_n = loop_on | ~st_q.ctrl[CB_OUT1];
    assign out2_n = loop_on | ~st_q.ctrl[CB_OUT2];
    assign irq    = |delta_q;
endmodule

// File: rtl/modem_ctl_stat_chk.sv
module modem_ctl_stat_chk #(
    parameter int ADDR_W   = 3,
    parameter int CTRL_OFS = 4,
    parameter int STAT_OFS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input logic              irq,
    input logic              dtr_n,
    input logic              rts_n,
    input logic              out1_n,
    input logic              out2_n,
    input logic [3:0]        delta_q,
    input logic [3:0]        prev_q,
    input logic [3:0]        chg
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic       stat_rd;
    logic [2:0] unused_rdata_hi;
    assign stat_rd         = rd_en && (addr == STAT_A);
    assign unused_rdata_hi = rdata[7:5];

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == STAT_A) |-> (irq == (|rdata[3:0]))); // R9

    AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr == CTRL_A) && rdata[4]) |-> ({dtr_n, rts_n, out1_n, out2_n} == 4'hF)); // R3

    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (delta_q == $past(chg))); // R8

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((delta_q & $past(delta_q)) == $past(delta_q))); // R8

    AST_RI_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[2]) |-> ($past(prev_q[2]) && !prev_q[2])); // R7

    AST_CTS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[0]) |-> (prev_q[0] != $past(prev_q[0]))); // R6
endmodule

bind modem_ctl_stat modem_ctl_stat_chk #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS),
    .STAT_OFS(STAT_OFS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .addr   (addr),
    .rdata  (rdata),
    .irq    (irq),
    .dtr_n  (dtr_n),
    .rts_n  (rts_n),
    .out1_n (out1_n),
    .out2_n (out2_n),
    .delta_q(delta_q),
    .prev_q (prev_q),
    .chg    (chg)
);

// File: tb/modem_ctl_stat_test.sv
`timescale 1ns/1ps
module modem_ctl_stat_test;
    logic       clk = 1'b0;
    logic       rst_n, wr_en, rd_en;
    logic [2:0] addr;
    logic [7:0] wdata, rdata;
    logic       cts_n, dsr_n, ri_n, dcd_n;
    logic       dtr_n, rts_n, out1_n, out2_n, irq;

    always #2 clk = ~clk;

    modem_ctl_stat uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n),
        .ri_n(ri_n), .dcd_n(dcd_n), .dtr_n(dtr_n), .rts_n(rts_n),
        .out1_n(out1_n), .out2_n(out2_n), .irq(irq)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // behavioural reference state
    int m_ctrl = 0;
    int m_prev = 0;
    int m_delta = 0;
    int pq[$] = '{0, 0};

    function automatic int m_lvl();
        if ((m_ctrl & 16) != 0)
            return ((m_ctrl >> 1) & 1) | ((m_ctrl & 1) << 1) | (m_ctrl & 12);
        return pq[0];
    endfunction

    function automatic int pins_now();
        return (cts_n ? 0 : 1) | (dsr_n ? 0 : 2) | (ri_n ? 0 : 4) | (dcd_n ? 0 : 8);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int l, c;
        l = m_lvl();
        c = ((m_prev ^ l) & 11) | (m_prev & ~l & 4);
        if (rd_en && addr == 3'd6) m_delta = 0;
        m_delta = m_delta | c;
        m_prev = l;
        if (wr_en && addr == 3'd4) m_ctrl = wdata & 31;
        pq.push_back(pins_now());
        pq.delete(0);
    endtask

    task automatic compare_all();
        int exp_rd, eo;
        if (addr == 3'd4) begin
            chk("R1 control readback", rdata, m_ctrl);
        end else if (addr == 3'd6) begin
            exp_rd = (m_lvl() << 4) | m_delta;
            chk("R4 status register", rdata, exp_rd);
        end else begin
            chk("R10 unmapped read", rdata, 0);
        end
        if ((m_ctrl & 16) != 0) begin
            chk("R3 outputs parked", {dtr_n, rts_n, out1_n, out2_n}, 15);
        end else begin
            eo = ((m_ctrl & 1) ? 0 : 8) | ((m_ctrl & 2) ? 0 : 4) |
                 ((m_ctrl & 4) ? 0 : 2) | ((m_ctrl & 8) ? 0 : 1);
            chk("R2 outputs", {dtr_n, rts_n, out1_n, out2_n}, eo);
        end
        chk("R9 irq", irq, (m_delta != 0) ? 1 : 0);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 3'd4; wdata = 8'h00;
        cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all();
        chk("R1 reset value", rdata, 8'h00);
        tick();

        // R1 / R2: write with upper bits set
        write_reg(3'd4, 8'hEF);
        chk("R1 upper bits read 0", rdata, 8'h0F);
        chk("R2 all outputs active", {dtr_n, rts_n, out1_n, out2_n}, 0);
        // R10: write elsewhere
        write_reg(3'd5, 8'h00);
        addr = 3'd4; tick();
        chk("R10 control unchanged", rdata, 8'h0F);
        addr = 3'd2; tick();
        chk("R10 unmapped read zero", rdata, 8'h00);

        // R6: CTS asserted
        addr = 3'd6;
        cts_n = 1'b0;
        repeat (3) tick();
        chk("R6 cts change", rdata, 8'h11);
        chk("R9 irq set", irq, 1);
        // R8: status read clears
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk("R8 cleared by read", rdata, 8'h10);
        chk("R9 irq clear", irq, 0);

        // R7: ring leading edge gives nothing, trailing edge flags
        ri_n = 1'b0;
        repeat (3) tick();
        chk("R7 no flag on ring start", rdata, 8'h50);
        ri_n = 1'b1;
        repeat (3) tick();
        chk("R7 flag on ring end", rdata, 8'h14);
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk("R8 cleared again", rdata, 8'h10);

        // R8: change detected on the reading edge survives
        dsr_n = 1'b0;
        tick(); tick();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk("R8 same-edge change kept", rdata, 8'h32);
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk("R8 later read clears", rdata, 8'h30);

        // R5 / R3: loopback with only the terminal-ready bit
        write_reg(3'd4, 8'h11);
        chk("R3 outputs parked", {dtr_n, rts_n, out1_n, out2_n}, 15);
        addr = 3'd6; tick();
        chk("R5 loop levels", rdata, 8'h21);
        dcd_n = 1'b0;
        repeat (4) tick();
        chk("R5 pins ignored", rdata, 8'h21);
        write_reg(3'd4, 8'h1E);
        addr = 3'd6; tick();
        chk("R5 loop remap", rdata, 8'hDB);

        // mixed traffic, compared on every clock
        for (int i = 0; i < 800; i++) begin
            if ($urandom_range(0, 15) == 0) cts_n = ~cts_n;
            if ($urandom_range(0, 15) == 0) dsr_n = ~dsr_n;
            if ($urandom_range(0, 11) == 0) ri_n  = ~ri_n;
            if ($urandom_range(0, 15) == 0) dcd_n = ~dcd_n;
            addr  = 3'($urandom_range(0, 7));
            rd_en = ($urandom_range(0, 5) == 0);
            wr_en = ($urandom_range(0, 23) == 0);
            wdata = 8'($urandom_range(0, 255));
            tick();
        end
        wr_en = 1'b0; rd_en = 1'b0;
        done = 1;
        finish_run();
    end
endmodule